// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block is a small datapath built around one shared bus. Four general registers, an address register (AR), a data register (DR) and a small word memory hang off it. A controller sets one source code and one destination code for each cycle. If the transfer enable is high, the destination register takes the bus value on the next rising clock edge, and the source register keeps its own value.

The bus normally carries the general register that the source code names. A constant input or DR can take its place. A swap option also writes the destination's old value back into the source register on the same edge, so the two registers trade contents in one cycle.

The memory is reached only through AR and DR. A read loads DR from the word that AR points to. A write stores DR into that word. AR is loaded from the low bits of DR. Every action requested in one cycle takes effect on the same clock edge and uses the values the registers held before that edge.

Top module: `rtb_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears the four general registers, AR and DR to zero on the next rising edge.
- R2: Register codes 0, 1, 2 and 3 name A, B, C and D, and register n occupies `regs_q[8n+7:8n]`. The bus carries `const_val` when `const_en` is 1. Otherwise it carries DR when `dr_to_bus` is 1. Otherwise it carries the register named by `src_sel`. With `xfer_en` high, the register named by `dst_sel` loads the bus value on the next edge.
- R3: With `xfer_en` low, no general register changes.
- R4: A transfer with `swap_en` low leaves the source register unchanged when source and destination differ.
- R5: With `xfer_en` and `swap_en` high, both select inputs `const_en` and `dr_to_bus` low, and distinct codes, the source register takes the destination's pre-edge value while the destination takes the source's pre-edge value. With equal codes the swap request has no effect.
- R6: `ar_load` loads AR with the low 4 bits of the pre-edge DR.
- R7: `dr_load` loads DR with the bus value.
- R8: `mem_rd` alone loads DR with the memory word at the pre-edge AR, and it takes priority over `dr_load`.
- R9: `mem_wr` alone stores the pre-edge DR into the word at AR. The stored word is seen by a later read.
- R10: `mem_rd` and `mem_wr` high together is ignored: memory keeps its contents and DR is not loaded from memory. With neither high, memory is unchanged.
- R11: All actions requested in one cycle take effect on the same edge and use pre-edge values. For example, AR takes the old DR while DR loads a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Code of the general register that drives the bus |
| dst_sel | input | 2 | Code of the general register that loads the bus |
| xfer_en | input | 1 | Control condition for the bus transfer |
| swap_en | input | 1 | Also write the destination's old value into the source register |
| const_en | input | 1 | Put `const_val` on the bus |
| const_val | input | 8 | Constant value for the bus |
| dr_to_bus | input | 1 | Put DR on the bus |
| dr_load | input | 1 | Load DR from the bus |
| ar_load | input | 1 | Load AR from the low field of DR |
| mem_rd | input | 1 | Memory read into DR |
| mem_wr | input | 1 | Memory write from DR |
| regs_q | output | 32 | General registers A to D, A in the lowest byte |
| ar_q | output | 4 | Address register |
| dr_q | output | 8 | Data register |

## Verification
Constants are loaded into all four registers, and transfers then run between several source and destination pairs. Equal codes are included, which separates a non-destructive copy from a swap. Swap requests are combined with constant and DR bus sources to show when the swap must be ignored. Memory writes go to several addresses before they are read back, which shows whether AR really steers the access. Cycles with read and write both high, or with read and DR load together, show the priority rules. A combined AR and DR load on one edge shows that old values are used.

// File: rtl/rtb_pkg.sv
package rtb_pkg;
  localparam int unsigned DEF_WIDTH = 8;
  localparam int unsigned DEF_AW    = 4;
  localparam int unsigned DEF_NREG  = 4;

  typedef enum logic [1:0] {
    REG_A = 2'd0,
    REG_B = 2'd1,
    REG_C = 2'd2,
    REG_D = 2'd3
  } reg_code_e;
endpackage

// File: rtl/rtb_bus_mux.sv
module rtb_bus_mux #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned NSRC  = 4,
  localparam int unsigned SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC*WIDTH-1:0] src_flat,
  input  logic [SEL_W-1:0]      sel,
  output logic [WIDTH-1:0]      y
);
  // one NSRC-to-1 selector per bus bit
  for (genvar gb = 0; gb < WIDTH; gb++) begin : g_bit
    logic [NSRC-1:0] column;
    for (genvar gs = 0; gs < NSRC; gs++) begin : g_src
      assign column[gs] = src_flat[gs*WIDTH + gb];
    end
    assign y[gb] = column[sel];
  end
endmodule

// File: rtl/rtb_dst_decoder.sv
module rtb_dst_decoder #(
  parameter int unsigned N = 4,
  localparam int unsigned SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [N-1:0]     hot
);
  always_comb begin
    hot = '0;
    if (en) hot[sel] = 1'b1;
  end
endmodule

// File: rtl/rtb_word_mem.sv
module rtb_word_mem #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned AW    = 4,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // combinational read so DR can capture M[AR] in the same edge
  assign rdata = mem[addr];
endmodule

// File: rtl/rtb_datapath.sv
module rtb_datapath
  import rtb_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned AW    = DEF_AW,
  parameter int unsigned NREG  = DEF_NREG,
  localparam int unsigned SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SEL_W-1:0]      src_sel,
  input  logic [SEL_W-1:0]      dst_sel,
  input  logic                  xfer_en,
  input  logic                  swap_en,
  input  logic                  const_en,
  input  logic [WIDTH-1:0]      const_val,
  input  logic                  dr_to_bus,
  input  logic                  dr_load,
  input  logic                  ar_load,
  input  logic                  mem_rd,
  input  logic                  mem_wr,
  output logic [NREG*WIDTH-1:0] regs_q,
  output logic [AW-1:0]         ar_q,
  output logic [WIDTH-1:0]      dr_q
);
  logic [WIDTH-1:0]      gp_q [NREG];
  logic [NREG*WIDTH-1:0] gp_flat;
  logic [WIDTH-1:0]      reg_bus;
  logic [WIDTH-1:0]      dst_val;
  logic [WIDTH-1:0]      bus_val;
  logic [WIDTH-1:0]      mem_rdata;
  logic [NREG-1:0]       ld_hot;
  logic [NREG-1:0]       sw_hot;
  logic                  swap_ok;
  logic                  rd_ok;
  logic                  wr_ok;

  for (genvar gi = 0; gi < NREG; gi++) begin : g_flat
    assign gp_flat[gi*WIDTH +: WIDTH] = gp_q[gi];
  end
  assign regs_q = gp_flat;

  // bus source from the general registers
  rtb_bus_mux #(.WIDTH(WIDTH), .NSRC(NREG)) u_src_mux (
    .src_flat (gp_flat),
    .sel      (src_sel),
    .y        (reg_bus)
  );

  // second path: destination's old value, used by a swap
  rtb_bus_mux #(.WIDTH(WIDTH), .NSRC(NREG)) u_swap_mux (
    .src_flat (gp_flat),
    .sel      (dst_sel),
    .y        (dst_val)
  );

  always_comb begin
    if (const_en)       bus_val = const_val;
    else if (dr_to_bus) bus_val = dr_q;
    else                bus_val = reg_bus;
  end

  assign swap_ok = xfer_en & swap_en & ~const_en & ~dr_to_bus
                 & (src_sel != dst_sel);

  rtb_dst_decoder #(.N(NREG)) u_dst_dec (
    .en  (xfer_en),
    .sel (dst_sel),
    .hot (ld_hot)
  );

  rtb_dst_decoder #(.N(NREG)) u_swap_dec (
    .en  (swap_ok),
    .sel (src_sel),
    .hot (sw_hot)
  );

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)             gp_q[gi] <= '0;
      else if (ld_hot[gi]) gp_q[gi] <= bus_val;
      else if (sw_hot[gi]) gp_q[gi] <= dst_val;
    end
  end

  assign rd_ok = mem_rd & ~mem_wr;
  assign wr_ok = mem_wr & ~mem_rd;

  always_ff @(posedge clk) begin
    if (rst)          ar_q <= '0;
    else if (ar_load) ar_q <= dr_q[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)          dr_q <= '0;
    else if (rd_ok)   dr_q <= mem_rdata;
    else if (dr_load) dr_q <= bus_val;
  end

  rtb_word_mem #(.WIDTH(WIDTH), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (wr_ok),
    .addr  (ar_q),
    .wdata (dr_q),
    .rdata (mem_rdata)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (regs_q == '0 && ar_q == '0 && dr_q == '0)); // R1
  AST_DEST_LOADS: assert property (@(posedge clk) disable iff (rst)
    xfer_en |=> gp_q[$past(dst_sel)] == $past(bus_val)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !xfer_en |=> regs_q == $past(regs_q)); // R3
  AST_SRC_KEPT: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && !swap_en && src_sel != dst_sel)
      |=> gp_q[$past(src_sel)] == $past(gp_q[src_sel])); // R4
  AST_SWAP_BACK: assert property (@(posedge clk) disable iff (rst)
    swap_ok |=> gp_q[$past(src_sel)] == $past(dst_val)); // R5
  AST_AR_FROM_DR: assert property (@(posedge clk) disable iff (rst)
    ar_load |=> ar_q == $past(dr_q[AW-1:0])); // R6
  AST_MEM_READ: assert property (@(posedge clk) disable iff (rst)
    rd_ok |=> dr_q == $past(mem_rdata)); // R8
  AST_MEM_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && !ar_load) |=> mem_rdata == $past(dr_q)); // R9
  AST_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_wr && !dr_load) |=> $stable(dr_q)); // R10
endmodule

// File: tb/rtb_datapath_tb.sv
module rtb_datapath_tb;
  import rtb_pkg::*;

  typedef struct {
    string       tag;
    logic [31:0] regs;
    logic [3:0]  ar;
    logic [7:0]  dr;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic [1:0] src_sel = '0, dst_sel = '0;
  logic       xfer_en = 0, swap_en = 0, const_en = 0, dr_to_bus = 0;
  logic [7:0] const_val = '0;
  logic       dr_load = 0, ar_load = 0, mem_rd = 0, mem_wr = 0;
  logic [31:0] regs_q;
  logic [3:0]  ar_q;
  logic [7:0]  dr_q;

  rtb_datapath u_dut (
    .clk(clk), .rst(rst), .src_sel(src_sel), .dst_sel(dst_sel),
    .xfer_en(xfer_en), .swap_en(swap_en), .const_en(const_en),
    .const_val(const_val), .dr_to_bus(dr_to_bus), .dr_load(dr_load),
    .ar_load(ar_load), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .regs_q(regs_q), .ar_q(ar_q), .dr_q(dr_q)
  );

  always #10 clk = ~clk; // 50 MHz

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;
  exp_t sb_q[$];

  logic [7:0] m_r [4];
  logic [3:0] m_ar;
  logic [7:0] m_dr;
  logic [7:0] m_mem [16];

  task automatic op(input string tag, input bit r,
                    input logic [1:0] s, input logic [1:0] d,
                    input bit x, input bit sw, input bit ce, input logic [7:0] k,
                    input bit d2b, input bit drl, input bit arl,
                    input bit rd, input bit wr);
    logic [7:0] bus;
    logic [7:0] nr [4];
    logic [3:0] nar;
    logic [7:0] ndr;
    exp_t e;
    rst = r; src_sel = s; dst_sel = d; xfer_en = x; swap_en = sw;
    const_en = ce; const_val = k; dr_to_bus = d2b; dr_load = drl;
    ar_load = arl; mem_rd = rd; mem_wr = wr;
    for (int i = 0; i < 4; i++) nr[i] = m_r[i];
    nar = m_ar; ndr = m_dr;
    bus = ce ? k : (d2b ? m_dr : m_r[s]);
    if (r) begin
      for (int i = 0; i < 4; i++) nr[i] = '0;
      nar = '0; ndr = '0;
    end else begin
      if (x) nr[d] = bus;
      if (x && sw && !ce && !d2b && s != d) nr[s] = m_r[d];
      if (arl) nar = m_dr[3:0];
      if (rd && !wr) ndr = m_mem[m_ar];
      else if (drl) ndr = bus;
      if (wr && !rd) m_mem[m_ar] = m_dr;
    end
    for (int i = 0; i < 4; i++) m_r[i] = nr[i];
    m_ar = nar; m_dr = ndr;
    e.tag = tag;
    e.regs = {m_r[3], m_r[2], m_r[1], m_r[0]};
    e.ar = m_ar; e.dr = m_dr;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    #5;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (regs_q !== e.regs || ar_q !== e.ar || dr_q !== e.dr) begin
        n_fail++;
        $display("FAIL %s: regs=%h ar=%h dr=%h expected regs=%h ar=%h dr=%h",
                 e.tag, regs_q, ar_q, dr_q, e.regs, e.ar, e.dr);
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_r[i] = 'x;
    m_ar = 'x; m_dr = 'x;
    @(negedge clk);
    //  tag                 r  s     d     x  sw ce k      d2b drl arl rd wr
    op("R1 reset",          1, REG_A, REG_A, 0, 0, 0, 8'h00, 0, 0, 0, 0, 0);
    op("R2 const A",        0, REG_A, REG_A, 1, 0, 1, 8'h11, 0, 0, 0, 0, 0);
    op("R2 const B",        0, REG_A, REG_B, 1, 0, 1, 8'h22, 0, 0, 0, 0, 0);
    op("R2 const C",        0, REG_A, REG_C, 1, 0, 1, 8'h33, 0, 0, 0, 0, 0);
    op("R2 const D",        0, REG_A, REG_D, 1, 0, 1, 8'hC4, 0, 0, 0, 0, 0);
    op("R2 R4 A to C",      0, REG_A, REG_C, 1, 0, 0, 8'hFF, 0, 0, 0, 0, 0);
    op("R2 R4 D to B",      0, REG_D, REG_B, 1, 0, 0, 8'h00, 0, 0, 0, 0, 0);
    op("R3 idle no xfer",   0, REG_D, REG_A, 0, 1, 1, 8'h5A, 0, 0, 0, 0, 0);
    op("R2 const C again",  0, REG_A, REG_C, 1, 0, 1, 8'h3C, 0, 0, 0, 0, 0);
    op("R5 swap A C",       0, REG_A, REG_C, 1, 1, 0, 8'h00, 0, 0, 0, 0, 0);
    op("R5 swap same code", 0, REG_B, REG_B, 1, 1, 0, 8'h00, 0, 0, 0, 0, 0);
    op("R5 swap w const",   0, REG_B, REG_D, 1, 1, 1, 8'h77, 0, 0, 0, 0, 0);
    op("R7 DR from bus",    0, REG_C, REG_A, 0, 0, 0, 8'h00, 0, 1, 0, 0, 0);
    op("R7 DR from const",  0, REG_C, REG_A, 0, 0, 1, 8'hA5, 0, 1, 0, 0, 0);
    op("R2 DR onto bus",    0, REG_A, REG_B, 1, 1, 0, 8'h00, 1, 0, 0, 0, 0);
    op("R6 R11 AR and DR",  0, REG_D, REG_A, 0, 0, 1, 8'h9E, 0, 1, 1, 0, 0);
    op("R9 write 5",        0, REG_A, REG_A, 0, 0, 0, 8'h00, 0, 0, 0, 0, 1);
    op("R11 AR=E DR=66",    0, REG_A, REG_A, 0, 0, 1, 8'h66, 0, 1, 1, 0, 0);
    op("R9 write E",        0, REG_A, REG_A, 0, 0, 0, 8'h00, 0, 0, 0, 0, 1);
    op("R7 DR=05",          0, REG_A, REG_A, 0, 0, 1, 8'h05, 0, 1, 0, 0, 0);
    op("R6 AR=5",           0, REG_A, REG_A, 0, 0, 0, 8'h00, 0, 0, 1, 0, 0);
    op("R8 read 5 over ld", 0, REG_A, REG_A, 0, 0, 1, 8'hEE, 0, 1, 0, 1, 0);
    op("R7 DR=0E",          0, REG_A, REG_A, 0, 0, 1, 8'h0E, 0, 1, 0, 0, 0);
    op("R6 AR=E",           0, REG_A, REG_A, 0, 0, 0, 8'h00, 0, 0, 1, 0, 0);
    op("R10 rd wr both",    0, REG_A, REG_A, 0, 0, 0, 8'h00, 0, 0, 0, 1, 1);
    op("R10 rd wr with ld", 0, REG_A, REG_A, 0, 0, 1, 8'h81, 0, 1, 0, 1, 1);
    op("R8 read E kept",    0, REG_A, REG_A, 0, 0, 0, 8'h00, 0, 0, 0, 1, 0);
    op("R2 mem word to D",  0, REG_A, REG_D, 1, 0, 0, 8'h00, 1, 0, 0, 0, 0);
    op("R1 reset again",    1, REG_B, REG_C, 1, 1, 1, 8'hFF, 0, 1, 1, 1, 0);
    op("R3 idle after rst", 0, REG_A, REG_A, 0, 0, 0, 8'h00, 0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule